// File: doc/BRIEF.md
# Temperature Threshold Alarm Register Unit

This block is the temperature-monitor core of a memory-module sensor hub. An external sensing path presents signed 11-bit temperature samples in quarter-degree steps, together with a one-cycle valid strobe. The core keeps the latest sample and four programmable limits: high, low, critical and low critical. It compares each accepted sample against those limits and sets sticky alarm flags. The bus side is a byte-wide register port with an 8-bit address and separate read and write strobes.

Accepted samples go through a two-state sequencer. `ST_IDLE` waits for a valid strobe while the sensor is enabled. The transition *accept* loads the sample and moves to `ST_EVAL`. `ST_EVAL` latches the comparison outcome and always takes the transition *done* back to `ST_IDLE`.

Alarm flags accumulate from the latched outcome. Software clears them by writing a mask to a clear register. A flag whose condition is still latched sets again in the same cycle as the clear. A disable bit stops sample acceptance, freezes the temperature reading and drops the latched outcome.

Top module: `thermal_limit_regs`

## Requirements
- R1: After reset, every limit byte, both temperature bytes, the status register (0x33) and the configuration register (0x1A) read 0x00, so the sensor starts enabled.
- R2: A read strobe registers the selected byte onto `bus_rdata` at the next clock edge, and `bus_rdata` holds while no read strobe is given. Address 0x00 reads 0x51, 0x01 reads 0x18 and 0x05 reads 0x02.
- R3: Each limit is a 16-bit little-endian pair: high at 0x1C/0x1D, low at 0x1E/0x1F, critical at 0x20/0x21 and low critical at 0x22/0x23. Bits [12:2] hold the 11-bit two's-complement value in 0.25 °C units. Bits [1:0] and [15:13] read as zero whatever is written.
- R4: An accepted sample appears at 0x31 (low byte) and 0x32 (high byte) in the same [12:2] format. Writes to these addresses are ignored.
- R5: Status at 0x33 carries bit 0 for temp > high, bit 1 for temp < low, bit 2 for temp > critical and bit 3 for temp < low critical. All comparisons are strict and signed. A flag becomes visible three clock edges after the edge that accepts the sample.
- R6: A status bit stays set after later samples return inside the limits.
- R7: Writing a mask to 0x13 clears the matching status bits (bit n of the mask clears bit n). A bit whose condition still holds for the last evaluated sample stays set.
- R8: Addresses 0x13 and 0x14 always read 0x00.
- R9: Bit 0 of 0x1A disables the sensor (1 = disabled), and bits [7:1] read zero. While the sensor is disabled, samples are ignored, the temperature reading holds and no status bit sets. Disabling also discards the held condition, so re-enabling sets nothing until a new sample is evaluated.
- R10: Reads of unmapped addresses return 0x00. Writes to read-only or unmapped addresses (for example 0x05, 0x33, 0x40) change nothing.
- R11: The extremes of the range are represented exactly: -256.00 °C (code -1024) reads 0x00/0x10, and +255.75 °C (code 1023) reads 0xFC/0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld | input | 1 | One-cycle strobe marking a new sample |
| samp_temp | input | 11 | Sample, two's complement, 0.25 °C units |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| alarm | output | 4 | Live copy of the sticky status flags |

## Verification
The assertions assume that `samp_vld` never pulses in the cycle right after an accepted sample, because `ST_EVAL` ignores it. They also assume that read and write strobes are never asserted together. Each bench task drives at most one strobe per cycle and waits out the full three-edge evaluation path before it reads status or issues the next sample. It also writes limits only while no sample is in flight, so every comparison uses settled limits.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 16;
    localparam int NFLAG  = 4;

    // flag bit positions, also the limit slot order starting at A_LIM_BASE
    localparam int FLG_HI = 0;
    localparam int FLG_LO = 1;
    localparam int FLG_CR = 2;
    localparam int FLG_LC = 3;

    localparam logic [ADDR_W-1:0] A_ID0      = 8'h00;
    localparam logic [ADDR_W-1:0] A_ID1      = 8'h01;
    localparam logic [ADDR_W-1:0] A_CAP      = 8'h05;
    localparam logic [ADDR_W-1:0] A_CLR      = 8'h13;
    localparam logic [ADDR_W-1:0] A_ERRCLR   = 8'h14;
    localparam logic [ADDR_W-1:0] A_CFG      = 8'h1A;
    localparam logic [ADDR_W-1:0] A_LIM_BASE = 8'h1C;
    localparam logic [ADDR_W-1:0] A_TEMP_LO  = 8'h31;
    localparam logic [ADDR_W-1:0] A_TEMP_HI  = 8'h32;
    localparam logic [ADDR_W-1:0] A_STAT     = 8'h33;

    localparam logic [7:0] ID_BYTE0 = 8'h51;
    localparam logic [7:0] ID_BYTE1 = 8'h18;
    localparam logic [7:0] CAP_BYTE = 8'h02;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } samp_state_e;
endpackage

// File: rtl/tlr_limit_bank.sv
module tlr_limit_bank
    import tlr_pkg::*;
#(
    parameter int TEMP_W  = 11,
    parameter int LSB_POS = 2,
    parameter int NLIM    = NFLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [7:0]        rd_byte,
    output logic [TEMP_W-1:0] lim_o [NLIM]
);
    localparam int PAD_W = WORD_W - TEMP_W - LSB_POS;

    logic [WORD_W-1:0] word_v [NLIM];
    logic [NLIM-1:0]   hit_v;
    logic [7:0]        byte_v [NLIM];

    generate
        for (genvar g = 0; g < NLIM; g++) begin : g_slot
            localparam logic [ADDR_W-1:0] LO_A = A_LIM_BASE + ADDR_W'(2 * g);
            localparam logic [ADDR_W-1:0] HI_A = LO_A + 1'b1;

            logic [TEMP_W-1:0] lim_q;
            logic [WORD_W-1:0] nxt_word;

            assign word_v[g] = {{PAD_W{1'b0}}, lim_q, {LSB_POS{1'b0}}};

            always_comb begin
                nxt_word = word_v[g];
                if (wr_en && wr_addr == LO_A) begin
                    nxt_word[7:0] = wr_data;
                end else if (wr_en && wr_addr == HI_A) begin
                    nxt_word[15:8] = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lim_q <= '0;
                end else begin
                    lim_q <= nxt_word[LSB_POS +: TEMP_W];
                end
            end

            assign lim_o[g]  = lim_q;
            assign hit_v[g]  = (rd_addr == LO_A) || (rd_addr == HI_A);
            assign byte_v[g] = (rd_addr == LO_A) ? word_v[g][7:0] : word_v[g][15:8];
        end
    endgenerate

    always_comb begin
        rd_hit  = |hit_v;
        rd_byte = '0;
        for (int i = 0; i < NLIM; i++) begin
            if (hit_v[i]) begin
                rd_byte = rd_byte | byte_v[i];
            end
        end
    end
endmodule

// File: rtl/tlr_compare.sv
module tlr_compare
    import tlr_pkg::*;
#(
    parameter int TEMP_W = 11
) (
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] lim_i [NFLAG],
    output logic [NFLAG-1:0]  cond_o
);
    logic signed [TEMP_W-1:0] t_s;

    always_comb begin
        t_s            = $signed(temp_i);
        cond_o         = '0;
        cond_o[FLG_HI] = t_s > $signed(lim_i[FLG_HI]);
        cond_o[FLG_LO] = t_s < $signed(lim_i[FLG_LO]);
        cond_o[FLG_CR] = t_s > $signed(lim_i[FLG_CR]);
        cond_o[FLG_LC] = t_s < $signed(lim_i[FLG_LC]);
    end
endmodule

// File: rtl/tlr_sample_fsm.sv
module tlr_sample_fsm
    import tlr_pkg::*;
#(
    parameter int TEMP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [TEMP_W-1:0] samp_temp,
    input  logic              sens_dis,
    input  logic [NFLAG-1:0]  cond_i,
    output logic [TEMP_W-1:0] temp_o,
    output logic [NFLAG-1:0]  cond_o
);
    samp_state_e state_q, state_d;
    logic        accept;

    assign accept = (state_q == ST_IDLE) && samp_vld && !sens_dis;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (samp_vld && !sens_dis) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_o <= '0;
            cond_o <= '0;
        end else begin
            if (accept) begin
                temp_o <= samp_temp;
            end
            if (sens_dis) begin
                cond_o <= '0;
            end else if (state_q == ST_EVAL) begin
                cond_o <= cond_i;
            end
        end
    end

    AST_EVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EVAL |=> state_q == ST_IDLE); // R5
    AST_TEMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        sens_dis |=> $stable(temp_o)); // R9
endmodule

// File: rtl/thermal_limit_regs.sv
module thermal_limit_regs
    import tlr_pkg::*;
#(
    parameter int TEMP_W  = 11,
    parameter int LSB_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [TEMP_W-1:0] samp_temp,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic [NFLAG-1:0]  alarm
);
    localparam int PAD_W = WORD_W - TEMP_W - LSB_POS;

    logic              sens_dis_q;
    logic [NFLAG-1:0]  status_q;
    logic [NFLAG-1:0]  clr_mask;
    logic [NFLAG-1:0]  cond_raw, cond_q;
    logic [TEMP_W-1:0] temp_q;
    logic [TEMP_W-1:0] lims [NFLAG];
    logic              lim_hit;
    logic [7:0]        lim_byte;
    logic [WORD_W-1:0] temp_word;
    logic [7:0]        rd_nxt;

    tlr_limit_bank #(.TEMP_W(TEMP_W), .LSB_POS(LSB_POS), .NLIM(NFLAG)) u_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .rd_addr (bus_addr),
        .rd_hit  (lim_hit),
        .rd_byte (lim_byte),
        .lim_o   (lims)
    );

    tlr_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .temp_i (temp_q),
        .lim_i  (lims),
        .cond_o (cond_raw)
    );

    tlr_sample_fsm #(.TEMP_W(TEMP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_vld  (samp_vld),
        .samp_temp (samp_temp),
        .sens_dis  (sens_dis_q),
        .cond_i    (cond_raw),
        .temp_o    (temp_q),
        .cond_o    (cond_q)
    );

    assign clr_mask  = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NFLAG-1:0] : '0;
    assign temp_word = {{PAD_W{1'b0}}, temp_q, {LSB_POS{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sens_dis_q <= 1'b0;
            status_q   <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CFG) begin
                sens_dis_q <= bus_wdata[0];
            end
            status_q <= (status_q & ~clr_mask) | (sens_dis_q ? '0 : cond_q);
        end
    end

    always_comb begin
        rd_nxt = lim_hit ? lim_byte : 8'h00;
        case (bus_addr)
            A_ID0:     rd_nxt = ID_BYTE0;
            A_ID1:     rd_nxt = ID_BYTE1;
            A_CAP:     rd_nxt = CAP_BYTE;
            A_CFG:     rd_nxt = {7'b0, sens_dis_q};
            A_TEMP_LO: rd_nxt = temp_word[7:0];
            A_TEMP_HI: rd_nxt = temp_word[15:8];
            A_STAT:    rd_nxt = {{(8 - NFLAG){1'b0}}, status_q};
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_nxt;
        end
    end

    assign alarm = status_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ID0) |=> bus_rdata == 8'h51); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CLR) |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
    AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_CLR || bus_addr == A_ERRCLR)) |=> bus_rdata == 8'h00); // R8
    AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sens_dis_q |=> ((status_q & ~$past(status_q)) == '0)); // R9
    AST_CFG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CFG) |=> bus_rdata[7:1] == 7'b0); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h40) |=> bus_rdata == 8'h00); // R10
endmodule

// File: tb/sim_thermal_limit_regs.sv
module sim_thermal_limit_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [10:0] samp_temp = '0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  alarm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thermal_limit_regs u0 (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_temp(samp_temp),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .alarm(alarm)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [15:0] fmt(input int q);
        return {3'b000, q[10:0], 2'b00};
    endfunction

    task automatic set_lim(input logic [7:0] base, input int q);
        logic [15:0] w = fmt(q);
        wr(base, w[7:0]);
        wr(base + 8'd1, w[15:8]);
    endtask

    task automatic sample(input int q);
        @(negedge clk);
        samp_vld = 1'b1; samp_temp = q[10:0];
        @(negedge clk);
        samp_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 8'h1C; a <= 8'h23; a++) rd_chk("R1 limit", 8'(a), 8'h00);
        rd_chk("R1 temp lo", 8'h31, 8'h00);
        rd_chk("R1 temp hi", 8'h32, 8'h00);
        rd_chk("R1 status", 8'h33, 8'h00);
        rd_chk("R1 cfg", 8'h1A, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] d;
        rd_chk("R2 id0", 8'h00, 8'h51);
        rd_chk("R2 id1", 8'h01, 8'h18);
        rd_chk("R2 cap", 8'h05, 8'h02);
        @(negedge clk);
        bus_addr = 8'h01;
        @(negedge clk);
        chk("R2 hold without strobe", bus_rdata, 8'h02);
    endtask

    task automatic t_limits();
        logic [15:0] w;
        wr(8'h1E, 8'hFF);
        rd_chk("R3 low byte pad", 8'h1E, 8'hFC);
        wr(8'h1F, 8'hFF);
        rd_chk("R3 high byte pad", 8'h1F, 8'h1F);
        set_lim(8'h1C, 200);
        set_lim(8'h1E, -20);
        set_lim(8'h20, 400);
        set_lim(8'h22, -80);
        w = fmt(200);
        rd_chk("R3 high lo", 8'h1C, w[7:0]);
        rd_chk("R3 high hi", 8'h1D, w[15:8]);
        w = fmt(-80);
        rd_chk("R3 lcrit lo", 8'h22, w[7:0]);
        rd_chk("R3 lcrit hi", 8'h23, w[15:8]);
        w = fmt(400);
        rd_chk("R3 crit hi", 8'h21, w[15:8]);
    endtask

    task automatic t_compare();
        sample(200);
        rd_chk("R5 equal high is not above", 8'h33, 8'h00);
        sample(201);
        rd_chk("R5 above high", 8'h33, 8'h01);
        sample(401);
        rd_chk("R5 above crit", 8'h33, 8'h05);
        chk("R5 alarm port", {4'b0, alarm}, 8'h05);
        sample(50);
        rd_chk("R6 sticky after return", 8'h33, 8'h05);
        wr(8'h13, 8'h01);
        rd_chk("R7 clear bit0 only", 8'h33, 8'h04);
        wr(8'h13, 8'h04);
        rd_chk("R7 clear bit2", 8'h33, 8'h00);
        sample(-20);
        rd_chk("R5 equal low is not below", 8'h33, 8'h00);
        sample(-21);
        rd_chk("R5 below low", 8'h33, 8'h02);
        sample(-81);
        rd_chk("R5 below lcrit", 8'h33, 8'h0A);
        wr(8'h13, 8'h0F);
        rd_chk("R7 reassert while held", 8'h33, 8'h0A);
        sample(0);
        wr(8'h13, 8'h0F);
        rd_chk("R7 clear when cleared condition", 8'h33, 8'h00);
        rd_chk("R8 clear reg reads zero", 8'h13, 8'h00);
        rd_chk("R8 error clear reads zero", 8'h14, 8'h00);
    endtask

    task automatic t_temp();
        sample(-1024);
        rd_chk("R11 min lo", 8'h31, 8'h00);
        rd_chk("R11 min hi", 8'h32, 8'h10);
        sample(1023);
        rd_chk("R11 max lo", 8'h31, 8'hFC);
        rd_chk("R11 max hi", 8'h32, 8'h0F);
        wr(8'h31, 8'h55);
        wr(8'h32, 8'hAA);
        rd_chk("R4 temp lo read-only", 8'h31, 8'hFC);
        rd_chk("R4 temp hi read-only", 8'h32, 8'h0F);
        sample(0);
        wr(8'h13, 8'h0F);
        rd_chk("R4 status cleared", 8'h33, 8'h00);
    endtask

    task automatic t_disable();
        sample(210);
        wr(8'h1A, 8'hFF);
        rd_chk("R9 cfg pad", 8'h1A, 8'h01);
        wr(8'h13, 8'h0F);
        rd_chk("R9 clear while disabled", 8'h33, 8'h00);
        sample(1000);
        rd_chk("R9 no set while disabled", 8'h33, 8'h00);
        rd_chk("R9 temp held", 8'h31, 8'h48);
        wr(8'h1A, 8'h00);
        @(negedge clk);
        @(negedge clk);
        rd_chk("R9 re-enable sets nothing", 8'h33, 8'h00);
        sample(0);
        rd_chk("R9 new sample accepted", 8'h31, 8'h00);
    endtask

    task automatic t_unmapped();
        rd_chk("R10 unmapped 0x40", 8'h40, 8'h00);
        rd_chk("R10 unmapped 0x7F", 8'h7F, 8'h00);
        wr(8'h05, 8'hFF);
        rd_chk("R10 cap write ignored", 8'h05, 8'h02);
        wr(8'h33, 8'hFF);
        rd_chk("R10 status write ignored", 8'h33, 8'h00);
        wr(8'h40, 8'hFF);
        rd_chk("R10 unmapped write ignored", 8'h40, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_limits();
        t_compare();
        t_temp();
        t_disable();
        t_unmapped();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule